// File: doc/BRIEF.md
# Integer Arithmetic/Logic Unit with Operation Decoder

This block is the arithmetic core of a multi-cycle integer datapath. Two 32-bit operands arrive already selected from registers, immediates or the program counter. A 32-bit result and a zero flag leave the block. The main sequencer does not select the arithmetic function directly. It issues a 2-bit class code: a forced add for address and counter arithmetic, a forced subtract for branch comparison, or a request to decode the operation from the instruction opcode. A small decode stage turns that code, and the opcode when needed, into an internal function select.

The unit supports add, subtract, AND, OR, XOR, signed less-than and greater-than tests, and logical shifts in both directions. The shift amount comes from the second operand. The whole unit is combinational, so the result follows its inputs within the same cycle. Add and subtract wrap silently. The block has no overflow output.

Top module: `alu_unit`

## Requirements
- R1: With class code 2'b00 the result is opa + opb modulo 2^32.
- R2: The zero output is 1 exactly when all 32 result bits are 0, and 0 otherwise.
- R3: With class code 2'b01 the result is opa - opb modulo 2^32.
- R4: With class code 2'b10 the operation comes from the opcode, with opcode[5] = 0 and opcode[4] ignored. The low nibble selects the operation: 1 add, 2 subtract, 3 AND, 4 OR, 5 XOR, 6 set-less-than, 7 set-greater-than, 8 shift left, 9 shift right. This means 6'h01..6'h09 and 6'h11..6'h19 decode alike.
- R5: The AND, OR and XOR operations act bit by bit on the two operands.
- R6: Set-less-than and set-greater-than compare the operands as two's-complement signed values. Each returns 32'd1 when its comparison holds and 32'd0 otherwise, including when the operands are equal.
- R7: Both shifts move opa by opb[4:0] places and fill with zeros. opb[31:5] has no effect.
- R8: Class code 2'b11 yields the add result. Under class 2'b10, an opcode not listed in R4 also yields the add result.
- R9: Under class codes 2'b00 and 2'b01 the opcode input has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cls_i | input | 2 | Operation class from the sequencer |
| opcode_i | input | 6 | Instruction opcode, used under class 2'b10 |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand; low 5 bits give the shift amount |
| result_o | output | 32 | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The bench targets the boundaries of the signed comparisons:
- -1 against 1, and the most negative value against the most positive. A comparator that treated the operands as unsigned would return the inverted answer on both.
- Equal operands, where a sloppy less-or-equal test would return 1.

It checks that add and subtract wrap into the sign bit and through zero. A missing carry or a wrong borrow direction shows there, as does a zero flag that ignores the top bits.

For the shifts, it uses shift amounts whose upper bits are set, including an amount of exactly 32. A shifter that used more than five bits would clear the operand instead of passing it through.

Finally, it drives opcodes with bit 4 set, opcodes with bit 5 set, and opcodes that do not care under forced classes. A decoder that read the wrong bits would pick the wrong operation.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [1:0] {
    CLS_ADD = 2'b00,
    CLS_SUB = 2'b01,
    CLS_DEC = 2'b10,
    CLS_RSV = 2'b11
  } alu_cls_e;

  typedef enum logic [3:0] {
    FN_ADD = 4'd0,
    FN_SUB = 4'd1,
    FN_AND = 4'd2,
    FN_OR  = 4'd3,
    FN_XOR = 4'd4,
    FN_SLT = 4'd5,
    FN_SGT = 4'd6,
    FN_SHL = 4'd7,
    FN_SHR = 4'd8
  } alu_fn_e;

  // Low nibble of the opcode under decode class
  localparam logic [3:0] OPN_ADD = 4'h1;
  localparam logic [3:0] OPN_SUB = 4'h2;
  localparam logic [3:0] OPN_AND = 4'h3;
  localparam logic [3:0] OPN_OR  = 4'h4;
  localparam logic [3:0] OPN_XOR = 4'h5;
  localparam logic [3:0] OPN_SLT = 4'h6;
  localparam logic [3:0] OPN_SGT = 4'h7;
  localparam logic [3:0] OPN_SHL = 4'h8;
  localparam logic [3:0] OPN_SHR = 4'h9;

endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
#(
  parameter int OP_W = 6
) (
  input  logic [1:0]      cls_i,
  input  logic [OP_W-1:0] opcode_i,
  output alu_fn_e         fn_o
);

  localparam int NIB_W = 4;

  logic [NIB_W-1:0] nib;
  logic             top_clear;
  alu_fn_e          op_fn;

  assign nib       = opcode_i[NIB_W-1:0];
  assign top_clear = ~|opcode_i[OP_W-1:NIB_W+1];

  always_comb begin
    op_fn = FN_ADD;
    if (top_clear) begin
      case (nib)
        OPN_ADD: op_fn = FN_ADD;
        OPN_SUB: op_fn = FN_SUB;
        OPN_AND: op_fn = FN_AND;
        OPN_OR:  op_fn = FN_OR;
        OPN_XOR: op_fn = FN_XOR;
        OPN_SLT: op_fn = FN_SLT;
        OPN_SGT: op_fn = FN_SGT;
        OPN_SHL: op_fn = FN_SHL;
        OPN_SHR: op_fn = FN_SHR;
        default: op_fn = FN_ADD;
      endcase
    end
  end

  always_comb begin
    case (alu_cls_e'(cls_i))
      CLS_ADD: fn_o = FN_ADD;
      CLS_SUB: fn_o = FN_SUB;
      CLS_DEC: fn_o = op_fn;
      default: fn_o = FN_ADD;
    endcase
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int DATA_W   = 32,
  parameter bit DIR_LEFT = 1'b1
) (
  input  logic [DATA_W-1:0]         data_i,
  input  logic [$clog2(DATA_W)-1:0] amt_i,
  output logic [DATA_W-1:0]         data_o
);

  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] stg [SH_W+1];

  assign stg[0] = data_i;

  for (genvar s = 0; s < SH_W; s++) begin : g_stage
    if (DIR_LEFT) begin : g_left
      assign stg[s+1] = amt_i[s] ? (stg[s] << (1 << s)) : stg[s];
    end else begin : g_right
      assign stg[s+1] = amt_i[s] ? (stg[s] >> (1 << s)) : stg[s];
    end
  end

  assign data_o = stg[SH_W];

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  alu_fn_e           fn_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] y_o,
  output logic              zero_o
);

  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] sum, diff, shl, shr;
  logic              lt, gt;

  assign sum  = a_i + b_i;
  assign diff = a_i - b_i;
  assign lt   = $signed(a_i) < $signed(b_i);
  assign gt   = $signed(a_i) > $signed(b_i);

  alu_shift #(.DATA_W(DATA_W), .DIR_LEFT(1'b1)) u_shl (
    .data_i (a_i),
    .amt_i  (b_i[SH_W-1:0]),
    .data_o (shl)
  );

  alu_shift #(.DATA_W(DATA_W), .DIR_LEFT(1'b0)) u_shr (
    .data_i (a_i),
    .amt_i  (b_i[SH_W-1:0]),
    .data_o (shr)
  );

  always_comb begin
    case (fn_i)
      FN_ADD:  y_o = sum;
      FN_SUB:  y_o = diff;
      FN_AND:  y_o = a_i & b_i;
      FN_OR:   y_o = a_i | b_i;
      FN_XOR:  y_o = a_i ^ b_i;
      FN_SLT:  y_o = {{(DATA_W-1){1'b0}}, lt};
      FN_SGT:  y_o = {{(DATA_W-1){1'b0}}, gt};
      FN_SHL:  y_o = shl;
      FN_SHR:  y_o = shr;
      default: y_o = sum;
    endcase
  end

  assign zero_o = ~|y_o;

endmodule

// File: rtl/alu_unit.sv
module alu_unit
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int OP_W   = 6
) (
  input  logic [1:0]        cls_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);

  alu_fn_e fn;

  alu_op_decode #(.OP_W(OP_W)) u_dec (
    .cls_i    (cls_i),
    .opcode_i (opcode_i),
    .fn_o     (fn)
  );

  alu_core #(.DATA_W(DATA_W)) u_core (
    .fn_i   (fn),
    .a_i    (opa_i),
    .b_i    (opb_i),
    .y_o    (result_o),
    .zero_o (zero_o)
  );

endmodule

// File: rtl/alu_unit_chk.sv
module alu_unit_chk #(
  parameter int DATA_W = 32,
  parameter int OP_W   = 6
) (
  input logic [1:0]        cls_i,
  input logic [OP_W-1:0]   opcode_i,
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [DATA_W-1:0] result_o,
  input logic              zero_o
);

  localparam int SH_W = $clog2(DATA_W);

  logic known;
  logic is_cmp;
  logic is_shift;

  assign known = !$isunknown({cls_i, opcode_i, opa_i, opb_i, result_o, zero_o});

  assign is_cmp = (cls_i == 2'b10) &&
                  (opcode_i[OP_W-1:5] == '0) &&
                  ((opcode_i[3:0] == 4'h6) || (opcode_i[3:0] == 4'h7));

  assign is_shift = (cls_i == 2'b10) &&
                    (opcode_i[OP_W-1:5] == '0) &&
                    ((opcode_i[3:0] == 4'h8) || (opcode_i[3:0] == 4'h9));

  always_comb begin
    if (known) begin
      AST_ZERO_FLAG: assert (zero_o == (result_o == '0)); // R2
      if (cls_i == 2'b00) begin
        AST_CLS_ADD: assert (result_o == opa_i + opb_i); // R1
      end
      if (cls_i == 2'b01) begin
        AST_CLS_SUB: assert (result_o == opa_i - opb_i); // R3
      end
      if (cls_i == 2'b11) begin
        AST_RSV_ADD: assert (result_o == opa_i + opb_i); // R8
      end
      if (is_cmp) begin
        AST_CMP_BOOL: assert (result_o[DATA_W-1:1] == '0); // R6
      end
      if (is_shift && (opb_i[SH_W-1:0] == '0)) begin
        AST_SHIFT_NONE: assert (result_o == opa_i); // R7
      end
    end
  end

endmodule

bind alu_unit alu_unit_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
  .cls_i    (cls_i),
  .opcode_i (opcode_i),
  .opa_i    (opa_i),
  .opb_i    (opb_i),
  .result_o (result_o),
  .zero_o   (zero_o)
);

// File: tb/alu_unit_tb.sv
module alu_unit_tb;

  localparam int  NV   = 19;
  localparam time TCLK = 8ns;

  // {req[3:0], cls[1:0], op[5:0], a[31:0], b[31:0], exp[31:0]}
  localparam logic [107:0] VEC [NV] = '{
    {4'd1, 2'b00, 6'h3F, 32'h7FFFFFFF, 32'h00000001, 32'h80000000}, // R1 R9
    {4'd1, 2'b00, 6'h00, 32'hFFFFFFFF, 32'h00000001, 32'h00000000}, // R1 wrap, R2
    {4'd3, 2'b01, 6'h05, 32'h00000005, 32'h00000007, 32'hFFFFFFFE}, // R3 R9
    {4'd3, 2'b01, 6'h00, 32'h12345678, 32'h12345678, 32'h00000000}, // R3
    {4'd4, 2'b10, 6'h01, 32'h00000010, 32'h00000020, 32'h00000030}, // R4
    {4'd4, 2'b10, 6'h12, 32'h00000010, 32'h00000020, 32'hFFFFFFF0}, // R4
    {4'd5, 2'b10, 6'h03, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000}, // R5
    {4'd5, 2'b10, 6'h04, 32'hF0F0F0F0, 32'h0F0F0000, 32'hFFFFF0F0}, // R5
    {4'd5, 2'b10, 6'h15, 32'hAAAA5555, 32'hFFFF0000, 32'h55555555}, // R5
    {4'd6, 2'b10, 6'h06, 32'hFFFFFFFF, 32'h00000001, 32'h00000001}, // R6
    {4'd6, 2'b10, 6'h06, 32'h00000001, 32'hFFFFFFFF, 32'h00000000}, // R6
    {4'd6, 2'b10, 6'h07, 32'h00000001, 32'h80000000, 32'h00000001}, // R6
    {4'd6, 2'b10, 6'h17, 32'h80000000, 32'h7FFFFFFF, 32'h00000000}, // R6
    {4'd7, 2'b10, 6'h08, 32'h00000001, 32'hFFFFFFE4, 32'h00000010}, // R7
    {4'd7, 2'b10, 6'h09, 32'h80000000, 32'h0000001F, 32'h00000001}, // R7
    {4'd7, 2'b10, 6'h19, 32'h80000000, 32'h00000020, 32'h80000000}, // R7
    {4'd8, 2'b11, 6'h02, 32'h00000003, 32'h00000004, 32'h00000007}, // R8
    {4'd8, 2'b10, 6'h3E, 32'h00000003, 32'h00000004, 32'h00000007}, // R8
    {4'd6, 2'b10, 6'h06, 32'h00000005, 32'h00000005, 32'h00000000}  // R6 equal
  };

  logic        clk;
  logic [1:0]  cls;
  logic [5:0]  opcode;
  logic [31:0] opa, opb;
  logic [31:0] result;
  logic        zero;

  int  n_cmp  = 0;
  int  n_bad  = 0;
  bit  done   = 1'b0;

  alu_unit u_dut (
    .cls_i    (cls),
    .opcode_i (opcode),
    .opa_i    (opa),
    .opb_i    (opb),
    .result_o (result),
    .zero_o   (zero)
  );

  initial clk = 1'b0;
  always #(TCLK/2) clk = ~clk;

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic apply(logic [1:0] c, logic [5:0] o, logic [31:0] a, logic [31:0] b);
    @(posedge clk);
    cls    = c;
    opcode = o;
    opa    = a;
    opb    = b;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(TCLK * 200000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cls = 2'b00; opcode = '0; opa = '0; opb = '0;
    @(negedge clk);
    // idle state: all-zero inputs give zero result, flag high
    check("R1 idle result", result, 32'h0);
    check("R2 idle zero", {31'b0, zero}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      logic [107:0] v;
      string        tg;
      v = VEC[i];
      apply(v[103:102], v[101:96], v[95:64], v[63:32]);
      tg = $sformatf("R%0d vec%0d", v[107:104], i);
      check(tg, result, v[31:0]);
      check({"R2 ", tg}, {31'b0, zero}, {31'b0, (v[31:0] == 32'h0)});
    end

    // R6: greater-than on equal operands
    apply(2'b10, 6'h07, 32'h80000000, 32'h80000000);
    check("R6 sgt equal", result, 32'h0);
    // R7: maximum left shift
    apply(2'b10, 6'h18, 32'hFFFFFFFF, 32'h0000003F);
    check("R7 shl 31", result, 32'h80000000);
    // R5 and R2: XOR of equal values
    apply(2'b10, 6'h05, 32'hDEADBEEF, 32'hDEADBEEF);
    check("R5 xor self", result, 32'h0);
    check("R2 xor self zero", {31'b0, zero}, 32'h1);
    // R9: subtract class ignores a shift opcode
    apply(2'b01, 6'h08, 32'h00000001, 32'h00000002);
    check("R9 sub ignores op", result, 32'hFFFFFFFF);
    check("R2 nonzero flag", {31'b0, zero}, 32'h0);
    // R4: opcode with bit 5 set is not decoded as AND
    apply(2'b10, 6'h23, 32'h0000000F, 32'h000000F0);
    check("R8 op bit5 add", result, 32'h000000FF);

    finish_run();
  end

endmodule